// File: doc/BRIEF.md
# Block-Move DMA Controller

A single-channel direct memory access engine that copies a run of words from one region of a shared memory bus to another. The data never passes through the processor. Software loads a source address, a destination address and a word count through a small register port. It then writes a control word that picks a bus-holding mode and sets the start bit.

Before it drives the bus, the controller asks for ownership with `bus_req` and waits for `bus_grant`. The mode sets how long it keeps the bus:
- **Cycle-stealing mode** gives the bus back after every word.
- **Block mode** holds the bus until the whole run has moved, so the processor stays stalled for that time.
- **Idle-cycle mode** holds the request but only strobes the bus in cycles that the processor reports as unused.

When the run finishes, a sticky `done` flag rises together with a one-cycle `irq` pulse.

Each word takes a read cycle on the source address and then a write cycle on the destination address. Memory returns read data in the cycle after `mem_rd`. Both addresses step up by one after each word, and the remaining count steps down by one.

Top module: `blkmove_dma`

## Requirements
- R1: After reset, `bus_req`, `mem_rd`, `mem_wr`, `done` and `irq` are all low.
- R2: A run of length N copies the N words at source, source+1, … to destination, destination+1, … in ascending order. It writes exactly N words, leaves the word at destination+N untouched and leaves the source words unchanged.
- R3: `mem_rd` and `mem_wr` are asserted only while `bus_grant` is high. No access occurs in the cycle in which `bus_req` first rises.
- R4: In mode value 0 (cycle stealing), `bus_req` goes low after every written word. Over a run of N words it falls exactly N times.
- R5: In mode values 1 and 3 (block), `bus_req` rises once per run and stays high from the first word to the last.
- R6: In mode value 2 (idle-cycle), `bus_req` rises once per run. `mem_rd` and `mem_wr` are asserted only in cycles where `cpu_idle` is high, and the read step does not advance while `cpu_idle` is low.
- R7: At the end of a run, `done` rises and stays high. `irq` is high for exactly one cycle, and that is the cycle in which `done` first reads high.
- R8: A start with a length of 0 sets `done` and pulses `irq` in the cycle after the start write, and never raises `bus_req`.
- R9: Writing the control word with the start bit set (bit 0) clears `done` from the next cycle.
- R10: Register writes and start requests that arrive while a run is active do not change that run's addresses, length or mode, and do not launch a second run.
- R11: Register select values are 0 for source, 1 for destination, 2 for length and 3 for control. In the control word, bit 0 is start and bits 2:1 are the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 source, 1 destination, 2 length, 3 control) |
| cfg_wdata | input | AW | Register write data |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_grant | input | 1 | Bus ownership granted to this controller |
| cpu_idle | input | 1 | Processor reports the bus unused this cycle |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after `mem_rd` |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A wrong remaining count shows at the ports within one run: either the number of `mem_wr` strobes is wrong or the sentinel word past the destination is overwritten, and `irq` arrives early or late. A stuck or mis-decoded mode shows within two words, because the request either drops where it should stay high or stays high where it should drop. A stale read-data holding register shows as a wrong destination word only in idle-cycle runs, where the write is delayed after the read. A sweep over every mode value and several lengths, including 0, 1 and the maximum, therefore reaches each of these faults.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

    typedef enum logic [1:0] {
        MODE_STEAL  = 2'b00,
        MODE_BLOCK  = 2'b01,
        MODE_SNEAK  = 2'b10,
        MODE_BLOCK2 = 2'b11
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_READ,
        ST_WRITE,
        ST_GAP
    } fsm_state_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_LEN  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/blkmove_regs.sv
module blkmove_regs
    import blkmove_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] src_cfg,
    output logic [AW-1:0] dst_cfg,
    output logic [LW-1:0] len_cfg,
    output xfer_mode_e    mode_cfg,
    output logic          start
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        xfer_mode_e    mode;
    } regs_t;

    regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_SRC:  nxt_d.src  = cfg_wdata;
                SEL_DST:  nxt_d.dst  = cfg_wdata;
                SEL_LEN:  nxt_d.len  = cfg_wdata[LW-1:0];
                default:  nxt_d.mode = xfer_mode_e'(cfg_wdata[2:1]);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // The start request takes the mode being written in the same control word.
    assign start    = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0];
    assign src_cfg  = cur_q.src;
    assign dst_cfg  = cur_q.dst;
    assign len_cfg  = cur_q.len;
    assign mode_cfg = (cfg_we && cfg_sel == SEL_CTRL) ? xfer_mode_e'(cfg_wdata[2:1]) : cur_q.mode;

endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq #(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          rd_strobe,
    input  logic [AW-1:0] src_cfg,
    input  logic [AW-1:0] dst_cfg,
    input  logic [LW-1:0] len_cfg,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          last,
    output logic [DW-1:0] wdata
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] left;
        logic [DW-1:0] hold;
        logic          fresh;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.fresh = rd_strobe;
        if (cur_q.fresh) nxt_d.hold = mem_rdata;
        if (load) begin
            nxt_d.src  = src_cfg;
            nxt_d.dst  = dst_cfg;
            nxt_d.left = len_cfg;
        end else if (step) begin
            nxt_d.src  = cur_q.src + 1'b1;
            nxt_d.dst  = cur_q.dst + 1'b1;
            nxt_d.left = cur_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign src_addr = cur_q.src;
    assign dst_addr = cur_q.dst;
    assign last     = (cur_q.left == LW'(1));
    // Memory answers one cycle after the read; later writes use the held copy.
    assign wdata    = cur_q.fresh ? mem_rdata : cur_q.hold;

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (src_addr == AW'($past(src_addr) + 1'b1)) &&
                 (dst_addr == AW'($past(dst_addr) + 1'b1)));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cur_q.left == LW'($past(cur_q.left) - 1'b1));

endmodule

// File: rtl/blkmove_fsm.sv
module blkmove_fsm
    import blkmove_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       len_zero,
    input  xfer_mode_e mode_cfg,
    input  logic       bus_grant,
    input  logic       cpu_idle,
    input  logic       last,
    output logic       bus_req,
    output logic       rd_strobe,
    output logic       wr_strobe,
    output logic       wr_phase,
    output logic       load,
    output logic       done,
    output logic       irq
);

    typedef struct packed {
        fsm_state_e state;
        xfer_mode_e mode;
        logic       done;
        logic       irq;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic allowed;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.irq = 1'b0;
        load      = 1'b0;
        allowed   = bus_grant && ((cur_q.mode != MODE_SNEAK) || cpu_idle);
        rd_strobe = (cur_q.state == ST_READ)  && allowed;
        wr_strobe = (cur_q.state == ST_WRITE) && allowed;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.mode = mode_cfg;
                    if (len_zero) begin
                        nxt_d.done = 1'b1;
                        nxt_d.irq  = 1'b1;
                    end else begin
                        nxt_d.done  = 1'b0;
                        load        = 1'b1;
                        nxt_d.state = ST_ASK;
                    end
                end
            end
            ST_ASK: begin
                if (bus_grant) nxt_d.state = ST_READ;
            end
            ST_READ: begin
                if (rd_strobe) nxt_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_strobe) begin
                    if (last) begin
                        nxt_d.state = ST_IDLE;
                        nxt_d.done  = 1'b1;
                        nxt_d.irq   = 1'b1;
                    end else if (cur_q.mode == MODE_STEAL) begin
                        nxt_d.state = ST_GAP;
                    end else begin
                        nxt_d.state = ST_READ;
                    end
                end
            end
            ST_GAP: begin
                if (!bus_grant) nxt_d.state = ST_ASK;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{state: ST_IDLE, mode: MODE_STEAL, done: 1'b0, irq: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign bus_req  = (cur_q.state == ST_ASK) || (cur_q.state == ST_READ) || (cur_q.state == ST_WRITE);
    assign wr_phase = (cur_q.state == ST_WRITE);
    assign done     = cur_q.done;
    assign irq      = cur_q.irq;

    assert_no_access_on_ask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !(rd_strobe || wr_strobe));

    assert_steal_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == MODE_STEAL && wr_strobe && !last) |=> !bus_req);

    assert_block_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.mode == MODE_BLOCK || cur_q.mode == MODE_BLOCK2) && wr_strobe && !last)
        |=> bus_req && cur_q.state == ST_READ);

    assert_sneak_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == MODE_SNEAK && cur_q.state == ST_READ && !cpu_idle) |=> cur_q.state == ST_READ);

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE && start && len_zero) |=> done && irq && !bus_req);

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE && start && !len_zero) |=> !done);

endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma
    import blkmove_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          bus_req,
    input  logic          bus_grant,
    input  logic          cpu_idle,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          irq
);

    logic [AW-1:0] src_cfg, dst_cfg, src_addr, dst_addr;
    logic [LW-1:0] len_cfg;
    xfer_mode_e    mode_cfg;
    logic          start, load, last, rd_strobe, wr_strobe, wr_phase;

    blkmove_regs #(.AW(AW), .LW(LW)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .src_cfg(src_cfg), .dst_cfg(dst_cfg), .len_cfg(len_cfg), .mode_cfg(mode_cfg), .start(start)
    );

    blkmove_seq #(.AW(AW), .LW(LW), .DW(DW)) seq_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(wr_strobe), .rd_strobe(rd_strobe),
        .src_cfg(src_cfg), .dst_cfg(dst_cfg), .len_cfg(len_cfg), .mem_rdata(mem_rdata),
        .src_addr(src_addr), .dst_addr(dst_addr), .last(last), .wdata(mem_wdata)
    );

    blkmove_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .len_zero(len_cfg == '0), .mode_cfg(mode_cfg),
        .bus_grant(bus_grant), .cpu_idle(cpu_idle), .last(last), .bus_req(bus_req),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .wr_phase(wr_phase), .load(load),
        .done(done), .irq(irq)
    );

    assign mem_addr = wr_phase ? dst_addr : src_addr;
    assign mem_rd   = rd_strobe;
    assign mem_wr   = wr_strobe;

    assert_grant_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> bus_grant && bus_req);

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/blkmove_dma_tb.sv
module blkmove_dma_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          bus_req, mem_rd, mem_wr, done, irq;
    logic          bus_grant = 1'b0;
    logic          cpu_idle = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] mem [256];

    int checks = 0, errors = 0, cyc = 0;
    int wr_cnt = 0, rises = 0, falls = 0, grant_viol = 0, idle_viol = 0;
    logic prev_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkmove_dma #(.AW(AW), .DW(DW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_grant(bus_grant), .cpu_idle(cpu_idle), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .irq(irq)
    );

    // Memory with one-cycle read latency and a one-cycle registered arbiter.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        bus_grant <= rst_n && bus_req;
    end

    // Port monitor and idle-cycle pattern, away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (mem_wr) wr_cnt <= wr_cnt + 1;
            if ((mem_rd || mem_wr) && !bus_grant) grant_viol <= grant_viol + 1;
            if ((mem_rd || mem_wr) && dut_mode_sneak && !cpu_idle) idle_viol <= idle_viol + 1;
            if (bus_req && !prev_req) rises <= rises + 1;
            if (!bus_req && prev_req) falls <= falls + 1;
            prev_req <= bus_req;
        end
        cpu_idle <= ((cyc % 3) == 1);
    end

    logic dut_mode_sneak = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int seed, input int k);
        return DW'((k * 13 + seed * 7 + 5) & 8'hFF);
    endfunction

    task automatic prep(input int s, input int d, input int n, input int seed);
        for (int k = 0; k < 256; k++) mem[k] = 8'h00;
        for (int k = 0; k < n; k++) mem[s + k] = pat(seed, k);
        mem[d + n] = 8'hA5;
        cfg_write(2'd0, AW'(s));
        cfg_write(2'd1, AW'(d));
        cfg_write(2'd2, AW'(n));
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
    endtask

    task automatic verify(input int mode, input int s, input int d, input int n, input int seed,
                          input int w0, input int r0, input int f0);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            if (mem[d + k] !== pat(seed, k)) bad++;
            if (mem[s + k] !== pat(seed, k)) bad++;
        end
        chk(bad == 0, "R2 data copied", bad, 0);
        chk(mem[d + n] == 8'hA5, "R2 sentinel untouched", int'(mem[d + n]), 165);
        chk(wr_cnt - w0 == n, "R2 word count", wr_cnt - w0, n);
        chk(grant_viol == 0, "R3 access without grant", grant_viol, 0);
        if (mode == 0) chk(falls - f0 == n, "R4 release per word", falls - f0, n);
        else           chk(rises - r0 == 1, "R5/R6 single request", rises - r0, 1);
        if (mode == 2) chk(idle_viol == 0, "R6 idle-only access", idle_viol, 0);
    endtask

    task automatic run(input int mode, input int s, input int d, input int n, input int seed);
        int w0, r0, f0;
        bit seen;
        prep(s, d, n, seed);
        dut_mode_sneak = (mode == 2);
        w0 = wr_cnt; r0 = rises; f0 = falls;
        cfg_write(2'd3, AW'(mode * 2 + 1));
        chk(done == 1'b0, "R9 start clears done", int'(done), 0);
        wait_irq(seen);
        chk(seen, "R7 irq seen", int'(seen), 1);
        chk(done == 1'b1, "R7 done with irq", int'(done), 1);
        @(negedge clk);
        chk(irq == 1'b0 && done == 1'b1, "R7 irq one cycle, done sticky", int'({irq, done}), 1);
        repeat (3) @(negedge clk);
        verify(mode, s, d, n, seed, w0, r0, f0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int lens[4] = '{1, 2, 7, 31};
        int w0, r0;
        bit seen;
        repeat (3) @(negedge clk);
        chk({bus_req, mem_rd, mem_wr, done, irq} == 5'b0, "R1 reset outputs", int'({bus_req, mem_rd, mem_wr, done, irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bus_req, done, irq} == 3'b0, "R1 idle after reset", int'({bus_req, done, irq}), 0);

        // R8 zero length: done and irq in the cycle after the start write.
        r0 = rises;
        cfg_write(2'd2, 8'd0);
        cfg_write(2'd3, 8'd3);
        chk(done && irq, "R8 zero length completes", int'({done, irq}), 3);
        @(negedge clk);
        chk(!irq && done, "R8 irq pulse once", int'({irq, done}), 1);
        chk(rises == r0 && !bus_req, "R8 no bus request", rises - r0, 0);

        // Sweep all mode codes (R11) over several lengths: R2..R7, R9.
        for (int m = 0; m < 4; m++)
            for (int li = 0; li < 4; li++)
                run(m, 8'h10 + m * 8 + li, 8'h80 + li * 2, lens[li], m * 4 + li);

        // R10: writes and a start while a block run is active.
        prep(8'h40, 8'hA0, 10, 9);
        dut_mode_sneak = 1'b0;
        w0 = wr_cnt;
        cfg_write(2'd3, 8'd3);
        repeat (2) @(negedge clk);
        cfg_write(2'd0, 8'h00);
        cfg_write(2'd2, 8'd2);
        cfg_write(2'd3, 8'd5);
        wait_irq(seen);
        chk(seen, "R10 run completes", int'(seen), 1);
        repeat (30) @(negedge clk);
        chk(wr_cnt - w0 == 10, "R10 busy writes ignored", wr_cnt - w0, 10);
        chk(!bus_req, "R10 no second run", int'(bus_req), 0);
        begin
            int bad = 0;
            for (int k = 0; k < 10; k++) if (mem[8'hA0 + k] !== pat(9, k)) bad++;
            chk(bad == 0, "R10 data intact", bad, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule